// File: doc/BRIEF.md
# Video Interrupt Status and Enable Unit

This unit gathers six single-cycle event pulses from a video display controller and turns them into one interrupt request for the host. The six events are sprite collision, sprite overflow, raster-line match, sprite-table copy done, video-memory DMA done and vertical blank. Each event that arrives while its enable is set is held in a sticky pending flag. The flag stays set until the host reads the status byte.

The host loads enables through two decoded write ports. The control-register low byte holds the enables for collision, overflow, line match and vertical blank. The DMA-control register holds the enables for the two transfer-done events. A status read strobe, qualified by the host address bit 0, returns the pending flags. A low-side read also clears all the flags as a side effect. Index decoding and event generation happen elsewhere.

Top module: `vis_irq_unit`

## Requirements
- R1: After reset, every pending flag and every enable bit is 0, `irq_o` is 0, and a status read returns 0x00.
- R2: A status read with `stat_hi`=0 returns the pending flags on `stat_data` in this order: bit 0 collision, bit 1 overflow, bit 2 line match, bit 3 sprite-table copy done, bit 4 DMA done, bit 5 vertical blank. Bits 7:6 read as 0.
- R3: A status read with `stat_hi`=0 clears all pending flags at that clock edge, and `irq_o` is 0 after that edge when no enabled event arrives in the same cycle.
- R4: A status read with `stat_hi`=1 returns 0x00 and leaves the pending flags unchanged.
- R5: A control low-byte write sets the enables from its data bits: bit 0 collision, bit 1 overflow, bit 2 line match, bit 3 vertical blank. Data bits 7:4 have no effect on any enable.
- R6: A DMA-control write with `dmactl_hi`=0 sets the enables from its data bits: bit 0 DMA done (status bit 4), bit 1 sprite-table copy done (status bit 3). A DMA-control write with `dmactl_hi`=1 is ignored.
- R7: An event pulse whose enable is 0 at that edge does not set its pending flag.
- R8: An enabled event that arrives in the same cycle as a clearing status read is pending after that edge.
- R9: `irq_o` is registered. After every clock edge, it equals the OR over the six sources of (pending AND enable). A pending flag whose enable is later cleared stays pending, but it no longer drives `irq_o`.
- R10: A pending flag stays set until a status read with `stat_hi`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Event pulses, in status bit order |
| ctrl_we | input | 1 | Control-register low-byte write strobe |
| ctrl_data | input | 8 | Control-register write data |
| dmactl_we | input | 1 | DMA-control write strobe |
| dmactl_hi | input | 1 | High byte selected for the DMA-control write |
| dmactl_data | input | 8 | DMA-control write data |
| stat_rd | input | 1 | Status read strobe |
| stat_hi | input | 1 | Host address bit 0 for the status read |
| stat_data | output | 8 | Status read data, valid during `stat_rd` |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions treat `evt_i`, the write strobes and the read strobe as synchronous, single-cycle inputs that are sampled only at the rising edge. They assume the status data is used only while `stat_rd` is high. The clear property also assumes that no enabled event lands in the same cycle as the read. The bench drives every input one time unit after the rising edge and holds it for exactly one cycle. It raises a read strobe for only one cycle at a time. Same-cycle collisions between events and reads come only from the R8 case, which is excluded from the clear property by its antecedent.

// File: rtl/vis_pkg.sv
package vis_pkg;
  localparam int NUM_SRC = 6;
  localparam int STAT_W  = 8;
  localparam int CTRL_EN = 4;
  localparam int DMA_EN  = 2;

  localparam int SRC_COLL  = 0;
  localparam int SRC_OVFL  = 1;
  localparam int SRC_LINE  = 2;
  localparam int SRC_STAB  = 3;
  localparam int SRC_VDMA  = 4;
  localparam int SRC_VBLK  = 5;

  // place the two register fields into status bit order
  function automatic logic [NUM_SRC-1:0] map_enables(
      input logic [CTRL_EN-1:0] ctl, input logic [DMA_EN-1:0] dma);
    logic [NUM_SRC-1:0] m;
    m           = '0;
    m[SRC_COLL] = ctl[0];
    m[SRC_OVFL] = ctl[1];
    m[SRC_LINE] = ctl[2];
    m[SRC_VBLK] = ctl[3];
    m[SRC_VDMA] = dma[0];
    m[SRC_STAB] = dma[1];
    return m;
  endfunction

  function automatic logic irq_reduce(
      input logic [NUM_SRC-1:0] pend, input logic [NUM_SRC-1:0] en);
    return |(pend & en);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic [NUM_SRC-1:0] pend);
    logic [STAT_W-1:0] s;
    s = '0;
    s[NUM_SRC-1:0] = pend;
    return s;
  endfunction
endpackage

// File: rtl/vis_enable_regs.sv
module vis_enable_regs
  import vis_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_we,
  input  logic [7:0]         ctrl_data,
  input  logic               dmactl_we,
  input  logic               dmactl_hi,
  input  logic [7:0]         dmactl_data,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] en_d
);
  logic [CTRL_EN-1:0] ctl_q, ctl_d;
  logic [DMA_EN-1:0]  dma_q, dma_d;
  logic               dma_take;

  assign dma_take = dmactl_we && !dmactl_hi;
  assign ctl_d    = ctrl_we  ? ctrl_data[CTRL_EN-1:0]  : ctl_q;
  assign dma_d    = dma_take ? dmactl_data[DMA_EN-1:0] : dma_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      dma_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      dma_q <= dma_d;
    end
  end

  assign en_q = map_enables(ctl_q, dma_q);
  assign en_d = map_enables(ctl_d, dma_d);
endmodule

// File: rtl/vis_pending_bank.sv
module vis_pending_bank
  import vis_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic               clr_i,
  output logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] pend_d
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    logic hit;
    assign hit       = evt_i[i] && en_q[i];
    // an event wins over a clear in the same cycle
    assign pend_d[i] = hit || (pend_q[i] && !clr_i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_d[i];
    end
  end
endmodule

// File: rtl/vis_irq_gen.sv
module vis_irq_gen
  import vis_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend_d,
  input  logic [NUM_SRC-1:0] en_d,
  output logic               irq_o
);
  logic irq_d;
  assign irq_d = irq_reduce(pend_d, en_d);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_d;
  end
endmodule

// File: rtl/vis_irq_unit.sv
module vis_irq_unit
  import vis_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [5:0]   evt_i,
  input  logic         ctrl_we,
  input  logic [7:0]   ctrl_data,
  input  logic         dmactl_we,
  input  logic         dmactl_hi,
  input  logic [7:0]   dmactl_data,
  input  logic         stat_rd,
  input  logic         stat_hi,
  output logic [7:0]   stat_data,
  output logic         irq_o
);
  logic [NUM_SRC-1:0] en_q, en_d, pend_q, pend_d;
  logic               rd_clear;

  assign rd_clear = stat_rd && !stat_hi;

  vis_enable_regs u_en (
    .clk, .rst_n, .ctrl_we, .ctrl_data, .dmactl_we, .dmactl_hi, .dmactl_data,
    .en_q, .en_d
  );

  vis_pending_bank u_pend (
    .clk, .rst_n, .evt_i, .en_q, .clr_i(rd_clear), .pend_q, .pend_d
  );

  vis_irq_gen u_irq (
    .clk, .rst_n, .pend_d, .en_d, .irq_o
  );

  assign stat_data = rd_clear ? pack_status(pend_q) : '0;
endmodule

// File: rtl/vis_irq_unit_chk.sv
module vis_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] evt_i,
  input logic       stat_rd,
  input logic       stat_hi,
  input logic [7:0] stat_data,
  input logic       irq_o,
  input logic [5:0] pend_q,
  input logic [5:0] en_q
);
  // R2
  status_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !stat_hi) |-> (stat_data == {2'b00, pend_q}));
  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !stat_hi && ((evt_i & en_q) == 6'd0)) |=> (pend_q == 6'd0 && !irq_o));
  // R4
  high_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && stat_hi) |-> (stat_data == 8'h00));
  // R9
  irq_matches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(pend_q & en_q)));
  // R7
  rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~($past(evt_i) & $past(en_q))) == 6'd0));
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_rd && !stat_hi) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
endmodule

bind vis_irq_unit vis_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .stat_rd(stat_rd), .stat_hi(stat_hi),
  .stat_data(stat_data), .irq_o(irq_o), .pend_q(pend_q), .en_q(en_q)
);

// File: tb/tb_vis_irq_unit.sv
module tb_vis_irq_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] evt_i = '0;
  logic       ctrl_we = 1'b0, dmactl_we = 1'b0, dmactl_hi = 1'b0;
  logic [7:0] ctrl_data = '0, dmactl_data = '0;
  logic       stat_rd = 1'b0, stat_hi = 1'b0;
  logic [7:0] stat_data;
  logic       irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t sb[$];

  // bench model, independent of the RTL
  logic [5:0] m_pend = '0;
  logic       m_cc = 0, m_co = 0, m_cl = 0, m_cv = 0, m_dv = 0, m_ds = 0;

  vis_irq_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] model_en();
    return {m_cv, m_dv, m_ds, m_cl, m_co, m_cc};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data mid-cycle
  always @(negedge clk) begin
    if (rst_n && stat_rd) begin
      if (sb.size() == 0) check(1'b0, "SB-empty", stat_data, 8'hxx);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(stat_data === e.val, e.tag, stat_data, e.val);
      end
    end
  end

  // driver: one cycle of stimulus, starts and ends 1 unit after a rising edge
  task automatic cyc(input logic [5:0] ev, input bit cw, input logic [7:0] cd,
                     input bit dw, input bit dh, input logic [7:0] dd,
                     input bit rd, input bit rh, input string tag);
    logic [5:0] en_now;
    evt_i = ev; ctrl_we = cw; ctrl_data = cd; dmactl_we = dw; dmactl_hi = dh;
    dmactl_data = dd; stat_rd = rd; stat_hi = rh;
    if (rd) begin
      exp_t e;
      e.val = rh ? 8'h00 : {2'b00, m_pend};
      e.tag = tag;
      sb.push_back(e);
    end
    @(posedge clk);
    en_now = model_en();
    if (rd && !rh) m_pend = '0;
    m_pend = m_pend | (ev & en_now);
    if (cw) begin m_cc = cd[0]; m_co = cd[1]; m_cl = cd[2]; m_cv = cd[3]; end
    if (dw && !dh) begin m_dv = dd[0]; m_ds = dd[1]; end
    #1;
    evt_i = '0; ctrl_we = 0; dmactl_we = 0; stat_rd = 0; stat_hi = 0;
    check(irq_o === (|(m_pend & model_en())), {tag, "-irq R9"}, {7'd0, irq_o},
          {7'd0, |(m_pend & model_en())});
  endtask

  task automatic idle(input string tag);
    cyc(6'd0, 0, 8'h00, 0, 0, 8'h00, 0, 0, tag);
  endtask

  task automatic rd_lo(input string tag);
    cyc(6'd0, 0, 8'h00, 0, 0, 8'h00, 1, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD*1000);
    check(1'b0, "watchdog", 8'h00, 8'h01);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check(irq_o === 1'b0, "R1 irq", {7'd0, irq_o}, 8'h00);
    rd_lo("R1 read");
    // R5 upper control bits only: no enables
    cyc(6'd0, 1, 8'hF0, 0, 0, 8'h00, 0, 0, "R5 ctrl-hi-bits");
    cyc(6'h3F, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R5 evt");
    rd_lo("R5 no-latch R7");
    // R6 high-byte DMA write ignored
    cyc(6'd0, 0, 8'h00, 1, 1, 8'h03, 0, 0, "R6 hi-write");
    cyc(6'h3F, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R6 evt");
    rd_lo("R6 ignored");
    // R6 low DMA write enables bits 4 and 3 only
    cyc(6'd0, 0, 8'h00, 1, 0, 8'h01, 0, 0, "R6 dma0");
    cyc(6'h3F, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R6 evt2");
    rd_lo("R6 vdma-only");
    cyc(6'd0, 0, 8'h00, 1, 0, 8'h02, 0, 0, "R6 dma1");
    cyc(6'h3F, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R6 evt3");
    rd_lo("R6 stab-only");
    // R5 each control bit alone
    for (int b = 0; b < 4; b++) begin
      cyc(6'd0, 1, 8'h01 << b, 1, 0, 8'h00, 0, 0, "R5 ctrl-bit");
      cyc(6'h3F, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R5 evt-bit");
      rd_lo("R5 ctrl-map");
    end
    // R2 enable all, each source individually
    cyc(6'd0, 1, 8'h0F, 1, 0, 8'h03, 0, 0, "R2 en-all");
    for (int s = 0; s < 6; s++) begin
      cyc(6'h01 << s, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R2 evt");
      rd_lo("R2 layout");
      idle("R3 cleared");
    end
    // R4 high read returns zero, no clear; R10 sticky
    cyc(6'h15, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R4 set");
    cyc(6'd0, 0, 8'h00, 0, 0, 8'h00, 1, 1, "R4 hi-read");
    idle("R10 idle");
    idle("R10 idle2");
    rd_lo("R4 R10 still-pending");
    rd_lo("R3 after-clear");
    // R8 event during clearing read
    cyc(6'h02, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R8 pre");
    cyc(6'h20, 0, 8'h00, 0, 0, 8'h00, 1, 0, "R8 read+evt");
    rd_lo("R8 survived");
    // R9 disable with pending held
    cyc(6'h01, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R9 set");
    cyc(6'd0, 1, 8'h00, 0, 0, 8'h00, 0, 0, "R9 mask");
    cyc(6'd0, 1, 8'h01, 0, 0, 8'h00, 0, 0, "R9 unmask");
    rd_lo("R9 pend-kept");
    // R7 disabled source among enabled
    cyc(6'd0, 1, 8'h01, 1, 0, 8'h00, 0, 0, "R7 en-coll");
    cyc(6'h3F, 0, 8'h00, 0, 0, 8'h00, 0, 0, "R7 evt");
    rd_lo("R7 only-coll");
    idle("end");
    check(sb.size() == 0, "SB-drain", 8'(sb.size()), 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule